// File: doc/BRIEF.md
# H-Bridge Overcurrent Deglitch and Auto-Retry Supervisor

This block supervises one H-bridge. It receives one overcurrent flag per power switch (two high-side, two low-side) together with an over-temperature flag and an undervoltage flag. It turns them into a single registered bridge-off command and a two-bit fault code. An overcurrent flag must stay high for a programmable number of consecutive clock cycles before it counts as a real fault. This filters out switching spikes. A confirmed fault holds the bridge off for a fixed retry interval. The bridge is then released with no outside help.

Over-temperature holds the bridge off only while its flag is high. Undervoltage also forces the bridge off, and it wipes the supervisor's internal state: any partial deglitch count and any running lockout are cleared. The deglitch length and the retry interval are parameters in clock cycles. At 125 MHz, about 2 µs and 1 ms correspond to 250 and 125000 cycles.

Top module: `bridge_fault_sup`

## Requirements
- R1: After synchronous reset, `bridge_off` is 0 and `fault_code` is 2'b00 (no fault).
- R2: If any one of the four `oc_flag` bits is high for DEG_CYC consecutive clock edges, an overcurrent fault is confirmed. `bridge_off` goes to 1 and `fault_code` to 2'b01 at the next edge, so one edge later than the DEG_CYC-th edge and not before.
- R3: If every overcurrent flag is low on some edge before DEG_CYC consecutive high samples, the persistence count restarts from zero and no fault is recorded.
- R4: A confirmed overcurrent keeps `bridge_off` high for exactly RETRY_CYC cycles. The bridge is then re-enabled automatically.
- R5: Overcurrent flags have no effect during the lockout. If a flag is still high after re-enable, a full new deglitch interval of DEG_CYC edges must pass before the next shutdown.
- R6: While `ot_flag` is high, `bridge_off` is 1 and `fault_code` is 2'b10, one edge after the flag is sampled. Both outputs clear one edge after the flag drops, and no lockout remains.
- R7: While `uv_flag` is high, `bridge_off` is 1 and `fault_code` is 2'b11. It also clears any lockout in progress and any partial deglitch count.
- R8: Fault code priority is undervoltage (2'b11) over thermal (2'b10) over overcurrent lockout (2'b01).
- R9: Both outputs are registered. `bridge_off` is 1 exactly when `fault_code` is not 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| oc_flag | input | NUM_SW (4) | Per-switch overcurrent flags, active high |
| ot_flag | input | 1 | Over-temperature flag, active high |
| uv_flag | input | 1 | Undervoltage flag, active high |
| bridge_off | output | 1 | Disable all bridge switches when high |
| fault_code | output | 2 | 00 none, 01 overcurrent lockout, 10 thermal, 11 undervoltage |

## Verification
The assertions assume that all flags are already synchronous to `clk`, and that DEG_CYC and RETRY_CYC are at least two. Under those assumptions a confirmation can only follow an edge on which a flag was already active, and a lockout can end only at its terminal count. The bench drives every flag just after a falling edge and samples at falling edges. It uses short parameter values (6 and 30 cycles) so that each interval boundary can be checked on both sides: the last cycle before a change and the first cycle after it.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_OC   = 2'b01,
    FLT_OT   = 2'b10,
    FLT_UV   = 2'b11
  } fault_e;
endpackage

// File: rtl/oc_deglitch.sv
module oc_deglitch #(
  parameter int NUM_SW  = 4,
  parameter int DEG_CYC = 250
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              mask,
  input  logic [NUM_SW-1:0] oc_flag,
  output logic              trip
);
  localparam int CW = $clog2(DEG_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(DEG_CYC - 1);

  logic [NUM_SW-1:0] sw_hit;
  logic              active;
  logic [CW-1:0]     cnt;

  // qualify each switch flag individually; masked during lockout
  for (genvar i = 0; i < NUM_SW; i++) begin : g_sw
    assign sw_hit[i] = oc_flag[i] & ~mask;
  end

  assign active = |sw_hit;
  assign trip   = active && (cnt == LIM);

  always_ff @(posedge clk) begin
    if (rst || clr)        cnt <= '0;
    else if (!active)      cnt <= '0;
    else if (cnt == LIM)   cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  // R3: confirmation only after a run of active samples (DEG_CYC >= 2)
  a_r3_trip_after_run: assert property (@(posedge clk) disable iff (rst)
    trip |-> $past(active));

  // R5: a masked cycle leaves no persistence count behind
  a_r5_mask_clears: assert property (@(posedge clk) disable iff (rst)
    ($past(mask) && !$past(rst)) |-> (cnt == '0));
endmodule

// File: rtl/retry_timer.sv
module retry_timer #(
  parameter int RETRY_CYC = 125000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic trip,
  output logic lock
);
  localparam int CW = $clog2(RETRY_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(RETRY_CYC - 1);

  logic [CW-1:0] rcnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lock <= 1'b0;
      rcnt <= '0;
    end else if (lock) begin
      if (rcnt == LIM) begin
        lock <= 1'b0;
        rcnt <= '0;
      end else begin
        rcnt <= rcnt + 1'b1;
      end
    end else if (trip) begin
      lock <= 1'b1;
      rcnt <= '0;
    end
  end

  // R4: lockout only starts from a confirmed fault
  a_r4_lock_from_trip: assert property (@(posedge clk) disable iff (rst)
    $rose(lock) |-> $past(trip));

  // R4: lockout ends only at its terminal count unless wiped
  a_r4_release_terminal: assert property (@(posedge clk) disable iff (rst)
    ($fell(lock) && !$past(clr) && !$past(rst)) |-> ($past(rcnt) == LIM));
endmodule

// File: rtl/fault_merge.sv
module fault_merge
  import bfs_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   lock,
  input  logic   ot,
  input  logic   uv,
  output logic   off_q,
  output fault_e code_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      off_q  <= 1'b0;
      code_q <= FLT_NONE;
    end else if (uv) begin
      off_q  <= 1'b1;
      code_q <= FLT_UV;
    end else if (ot) begin
      off_q  <= 1'b1;
      code_q <= FLT_OT;
    end else if (lock) begin
      off_q  <= 1'b1;
      code_q <= FLT_OC;
    end else begin
      off_q  <= 1'b0;
      code_q <= FLT_NONE;
    end
  end

  // R8: undervoltage wins
  a_r8_uv_first: assert property (@(posedge clk) disable iff (rst)
    ($past(uv) && !$past(rst)) |-> (code_q == FLT_UV && off_q));

  // R6: thermal disables when undervoltage is absent
  a_r6_ot_off: assert property (@(posedge clk) disable iff (rst)
    ($past(ot) && !$past(uv) && !$past(rst)) |-> (code_q == FLT_OT && off_q));

  // R4: lockout holds the bridge off
  a_r4_lock_off: assert property (@(posedge clk) disable iff (rst)
    ($past(lock) && !$past(rst)) |-> off_q);
endmodule

// File: rtl/bridge_fault_sup.sv
module bridge_fault_sup
  import bfs_pkg::*;
#(
  parameter int NUM_SW    = 4,
  parameter int DEG_CYC   = 250,
  parameter int RETRY_CYC = 125000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_SW-1:0] oc_flag,
  input  logic              ot_flag,
  input  logic              uv_flag,
  output logic              bridge_off,
  output logic [1:0]        fault_code
);
  logic   trip;
  logic   lock;
  fault_e code;

  oc_deglitch #(.NUM_SW(NUM_SW), .DEG_CYC(DEG_CYC)) u_deg (
    .clk(clk), .rst(rst), .clr(uv_flag), .mask(lock),
    .oc_flag(oc_flag), .trip(trip)
  );

  retry_timer #(.RETRY_CYC(RETRY_CYC)) u_rty (
    .clk(clk), .rst(rst), .clr(uv_flag), .trip(trip), .lock(lock)
  );

  fault_merge u_mrg (
    .clk(clk), .rst(rst), .lock(lock), .ot(ot_flag), .uv(uv_flag),
    .off_q(bridge_off), .code_q(code)
  );

  assign fault_code = code;

  // R9: disable and status agree
  a_r9_off_matches_code: assert property (@(posedge clk) disable iff (rst)
    bridge_off == (fault_code != 2'b00));
endmodule

// File: tb/sim_bridge_fault_sup.sv
module sim_bridge_fault_sup;
  localparam int DEG = 6;
  localparam int RTY = 30;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] oc  = '0;
  logic       ot  = 1'b0;
  logic       uv  = 1'b0;
  logic       off;
  logic [1:0] code;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bridge_fault_sup #(.NUM_SW(4), .DEG_CYC(DEG), .RETRY_CYC(RTY)) u0 (
    .clk(clk), .rst(rst), .oc_flag(oc), .ot_flag(ot), .uv_flag(uv),
    .bridge_off(off), .fault_code(code)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic eo, input logic [1:0] ec);
    total++;
    if (off !== eo || code !== ec) begin
      bad++;
      $display("FAIL %s: off=%b code=%b expected off=%b code=%b", req, off, code, eo, ec);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1; tick(3);
    chk("R1", 1'b0, 2'b00);
    rst = 1'b0; tick(1);
    chk("R1", 1'b0, 2'b00);
  endtask

  // R2 and R4, each switch flag separately
  task automatic t_trip_each;
    for (int i = 0; i < 4; i++) begin
      oc = 4'b0001 << i;
      tick(DEG);   chk("R2", 1'b0, 2'b00);
      tick(1);     chk("R2", 1'b1, 2'b01);
      oc = '0;
      tick(RTY-1); chk("R4", 1'b1, 2'b01);
      tick(1);     chk("R4", 1'b0, 2'b00);
    end
  endtask

  task automatic t_glitch;
    oc = 4'b0001; tick(DEG-1);
    oc = 4'b0000; tick(1);
    oc = 4'b0010; tick(DEG-1);
    oc = 4'b0000; tick(3);
    chk("R3", 1'b0, 2'b00);
  endtask

  task automatic t_lock_ignore;
    oc = 4'b1000; tick(DEG+1); chk("R5", 1'b1, 2'b01);
    oc = 4'b0101; tick(RTY-1); chk("R5", 1'b1, 2'b01);
    tick(1);                   chk("R4", 1'b0, 2'b00);
    tick(DEG-1);               chk("R5", 1'b0, 2'b00);
    tick(1);                   chk("R5", 1'b1, 2'b01);
    oc = '0; tick(RTY);        chk("R5", 1'b0, 2'b00);
  endtask

  task automatic t_thermal;
    ot = 1'b1; tick(1); chk("R6", 1'b1, 2'b10);
    tick(4);            chk("R6", 1'b1, 2'b10);
    ot = 1'b0; tick(1); chk("R6", 1'b0, 2'b00);
  endtask

  task automatic t_uv;
    oc = 4'b0001; tick(DEG+1); chk("R8", 1'b1, 2'b01);
    oc = '0; ot = 1'b1; tick(1); chk("R8", 1'b1, 2'b10);
    uv = 1'b1; tick(1);          chk("R8", 1'b1, 2'b11);
    ot = 1'b0; tick(2);          chk("R7", 1'b1, 2'b11);
    uv = 1'b0; tick(1);          chk("R7", 1'b0, 2'b00);
    // partial count wiped by undervoltage
    oc = 4'b0100; tick(DEG-1);
    uv = 1'b1; tick(1);
    uv = 1'b0; tick(1);          chk("R7", 1'b0, 2'b00);
    tick(DEG-1);                 chk("R7", 1'b0, 2'b00);
    tick(1);                     chk("R7", 1'b1, 2'b01);
    oc = '0; tick(RTY);          chk("R9", 1'b0, 2'b00);
  endtask

  initial begin
    tick(1);
    t_reset();
    t_trip_each();
    t_glitch();
    t_lock_ignore();
    t_thermal();
    t_uv();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule